// File: doc/BRIEF.md
# Strap Capture and Dual-Role Status Indicator Pins

This block owns two bidirectional pads that serve two roles. While the chip is held in reset, the block reads the pads as configuration straps. The first pad picks the host bus width and the second picks the byte order. The block keeps the values it read at the final reset clock edge and offers them to the rest of the chip until the next reset.

Once reset is released, each pad can be driven as a status indicator. Each pad has its own enable bit, taken from the PHY control register. The first pad shows whether the link is up. Its active level depends on the captured bus width. While a frame is being sent or received, it flashes at about 10 Hz. The second pad shows the link speed. Its level sense depends on the captured byte order. Whenever a pad's indicator is not enabled, its output enable stays low and the pad remains an input.

Top module: `strap_led_ctrl`

## Requirements
- R1: `bus16` takes the value of `pad_w_in` at the last rising clock edge at which `rst_n` is low. 1 means 16-bit mode and 0 (pulled down, the default) means 32-bit mode.
- R2: `big_endian` takes the value of `pad_o_in` at the last rising clock edge at which `rst_n` is low. 1 means swapped (big-endian) and 0 (the default) means little-endian.
- R3: While `rst_n` stays high, `bus16` and `big_endian` hold their captured values whatever `pad_w_in` and `pad_o_in` do.
- R4: After any rising edge at which `rst_n` is low, `pad_w_oe` and `pad_o_oe` are both 0.
- R5: From the first rising edge at which `rst_n` is high, `pad_w_oe` follows `led_link_en` (control bit 11) and `pad_o_oe` follows `led_speed_en` (control bit 12). A clear bit gives an output enable of 0.
- R6: With no activity, `pad_w_out` equals `link_up` when `bus16`=0 (active high) and equals the inverse of `link_up` when `bus16`=1 (active low).
- R7: While `tx_busy` or `rx_busy` is high and the link is up, the link indicator starts lit. It then alternates between dark and lit every HALF cycles, where HALF = CLK_HZ/(2*BLINK_HZ) and the count runs over rising edges with activity present. In the same cycle that activity ends, the indicator returns to its steady link level.
- R8: `pad_o_out` equals `speed_100` when `big_endian`=0 and equals the inverse of `speed_100` when `big_endian`=1. Here 1 on `speed_100` means 100 Mb/s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously |
| pad_w_in | input | 1 | Input value of the bus-width/link pad |
| pad_o_in | input | 1 | Input value of the byte-order/speed pad |
| link_up | input | 1 | PHY link good |
| speed_100 | input | 1 | PHY speed, 1 = 100 Mb/s |
| tx_busy | input | 1 | Transmit in progress |
| rx_busy | input | 1 | Receive in progress |
| led_link_en | input | 1 | PHY control bit 11, link indicator enable |
| led_speed_en | input | 1 | PHY control bit 12, speed indicator enable |
| bus16 | output | 1 | Captured width strap, 1 = 16-bit |
| big_endian | output | 1 | Captured order strap, 1 = swapped |
| pad_w_out | output | 1 | Drive value for link pad |
| pad_w_oe | output | 1 | Output enable for link pad |
| pad_o_out | output | 1 | Drive value for speed pad |
| pad_o_oe | output | 1 | Output enable for speed pad |

## Verification
The strap outputs settle after the last reset edge and can be checked as soon as `rst_n` rises. The output enables change one rising edge after reset releases. After that they, like the steady link and speed levels, depend only on their inputs within the same cycle. The blink phase changes on the edge that completes each HALF-cycle count. Every stimulus is applied midway through the clock low phase. Its expected item is queued, and the monitor compares it at the next falling edge, so every result is read after its edge has settled. For the blink, the bench counts falling edges from the moment activity starts and predicts the phase from that count.

// File: rtl/strap_led_ctrl.sv
module strap_led_ctrl #(
  parameter int CLK_HZ   = 25_000_000,
  parameter int BLINK_HZ = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_w_in,
  input  logic pad_o_in,
  input  logic link_up,
  input  logic speed_100,
  input  logic tx_busy,
  input  logic rx_busy,
  input  logic led_link_en,
  input  logic led_speed_en,
  output logic bus16,
  output logic big_endian,
  output logic pad_w_out,
  output logic pad_w_oe,
  output logic pad_o_out,
  output logic pad_o_oe
);
  localparam int HALF = (CLK_HZ / (2 * BLINK_HZ)) < 1 ? 1 : CLK_HZ / (2 * BLINK_HZ);
  localparam int CW   = $clog2(HALF + 1);

  logic          running;
  logic          blink_ph;
  logic [CW-1:0] blink_cnt;
  logic          busy;

  assign busy = tx_busy | rx_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus16      <= pad_w_in;
      big_endian <= pad_o_in;
    end
  end

  always_ff @(posedge clk) begin
    running <= rst_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) begin
      blink_cnt <= '0;
      blink_ph  <= 1'b0;
    end else if (blink_cnt == CW'(HALF - 1)) begin
      blink_cnt <= '0;
      blink_ph  <= ~blink_ph;
    end else begin
      blink_cnt <= blink_cnt + 1'b1;
    end
  end

  assign pad_w_oe  = running & led_link_en;
  assign pad_o_oe  = running & led_speed_en;
  assign pad_w_out = (link_up & ~(busy & blink_ph)) ^ bus16;
  assign pad_o_out = speed_100 ^ big_endian;

  p_strap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(bus16) && $stable(big_endian)));

  p_oe_reset_r4: assert property (@(posedge clk)
    !rst_n |=> (!pad_w_oe && !pad_o_oe));

  p_oe_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (pad_w_oe == led_link_en && pad_o_oe == led_speed_en));

  p_link_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pad_w_out == (link_up ^ bus16)));

  p_blink_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !blink_ph);

  p_speed_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pad_o_oe |-> (pad_o_out == (speed_100 ^ big_endian)));
endmodule

// File: tb/tb_strap_led_ctrl.sv
module tb_strap_led_ctrl;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pad_w_in = 1'b0, pad_o_in = 1'b0;
  logic link_up = 1'b0, speed_100 = 1'b0, tx_busy = 1'b0, rx_busy = 1'b0;
  logic led_link_en = 1'b0, led_speed_en = 1'b0;
  logic bus16, big_endian, pad_w_out, pad_w_oe, pad_o_out, pad_o_oe;

  always #2 clk = ~clk;

  strap_led_ctrl #(.CLK_HZ(80), .BLINK_HZ(10)) dut (
    .clk(clk), .rst_n(rst_n), .pad_w_in(pad_w_in), .pad_o_in(pad_o_in),
    .link_up(link_up), .speed_100(speed_100), .tx_busy(tx_busy), .rx_busy(rx_busy),
    .led_link_en(led_link_en), .led_speed_en(led_speed_en),
    .bus16(bus16), .big_endian(big_endian), .pad_w_out(pad_w_out),
    .pad_w_oe(pad_w_oe), .pad_o_out(pad_o_out), .pad_o_oe(pad_o_oe));

  typedef struct {
    string      rid;
    string      what;
    logic [5:0] mask;
    logic [5:0] val;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  // vector order: bus16, big_endian, pad_w_out, pad_w_oe, pad_o_out, pad_o_oe
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [5:0] got;
      it = q.pop_front();
      got = {bus16, big_endian, pad_w_out, pad_w_oe, pad_o_out, pad_o_oe};
      checks++;
      if ((got & it.mask) !== (it.val & it.mask)) begin
        errors++;
        $display("FAIL %s %s: actual=%b expected=%b (mask %b)", it.rid, it.what,
                 got & it.mask, it.val & it.mask, it.mask);
      end
    end
  end

  task automatic expect_at_fall(string rid, string what, logic [5:0] mask, logic [5:0] val);
    q.push_back('{rid, what, mask, val});
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); #1;
    for (int c = 0; c < 4; c++) begin
      logic s16, sbe;
      s16 = c[0];
      sbe = c[1];
      rst_n = 1'b0;
      led_link_en = 1'b1;
      led_speed_en = 1'b1;
      pad_w_in = s16;
      pad_o_in = sbe;
      repeat (2) @(negedge clk);
      #1;
      expect_at_fall("R4", "oe low in reset", 6'b000101, 6'b000000);
      rst_n = 1'b1;
      pad_w_in = ~s16;
      pad_o_in = ~sbe;
      expect_at_fall("R1", "width strap", 6'b100000, {s16, 5'b0});
      expect_at_fall("R2", "order strap", 6'b010000, {1'b0, sbe, 4'b0});
      repeat (3) @(negedge clk);
      #1;
      expect_at_fall("R3", "straps held", 6'b110000, {s16, sbe, 4'b0});
      expect_at_fall("R5", "both enabled", 6'b000101, 6'b000101);
      link_up = 1'b1;
      expect_at_fall("R6", "link up level", 6'b001000, {2'b0, 1'b1 ^ s16, 3'b0});
      link_up = 1'b0;
      expect_at_fall("R6", "link down level", 6'b001000, {2'b0, s16, 3'b0});
      speed_100 = 1'b1;
      expect_at_fall("R8", "100M level", 6'b000010, {4'b0, 1'b1 ^ sbe, 1'b0});
      speed_100 = 1'b0;
      expect_at_fall("R8", "10M level", 6'b000010, {4'b0, sbe, 1'b0});
      led_link_en = 1'b0;
      expect_at_fall("R5", "link oe off", 6'b000101, 6'b000001);
      led_speed_en = 1'b0;
      led_link_en = 1'b1;
      expect_at_fall("R5", "speed oe off", 6'b000101, 6'b000100);
      link_up = 1'b1;
      if (c[0]) rx_busy = 1'b1; else tx_busy = 1'b1;
      for (int k = 1; k <= 9; k++) begin
        logic lit;
        lit = ((k / HALF) % 2) == 0;
        expect_at_fall("R7", "blink phase", 6'b001000, {2'b0, lit ^ s16, 3'b0});
      end
      tx_busy = 1'b0;
      rx_busy = 1'b0;
      expect_at_fall("R7", "steady after activity", 6'b001000, {2'b0, 1'b1 ^ s16, 3'b0});
      link_up = 1'b0;
    end
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule